// File: doc/BRIEF.md
# Programmable Multi-Bank Chip Select Decoder

This block turns a bus address and its access attributes into one active-low chip select out of eight. Each channel holds three settings. The first is a 16-bit base that is compared with the top half of the address. The second is a mask word, which carries per-bit address don't-cares, access-type blocking bits, a write-protect bit and a valid bit. The third is a control word, which carries a wait-state count, an auto-acknowledge enable, a port size and the burst and byte-enable mode flags. Software programs the channels through a narrow write-only configuration port.

Each bus cycle opens with a one-cycle start strobe that carries the address and its attributes: read/write, supervisor/user, code/data, CPU-space and external master. If exactly one channel matches, its select is held low for the rest of the cycle. The block also reports the channel's port size and flags. If auto-acknowledge is set, the block raises an internal acknowledge once the programmed number of wait states has passed. If no channel matches, or more than one does, the block marks the cycle as an external one. That cycle is 32 bits wide, has bursts inhibited, and ends only on an external acknowledge.

Out of reset, channel 0 acts as a catch-all select so that boot code can be fetched from any address. This global mode ends the first time channel 0's valid bit is written to 1.

Top module: `cs_decoder`

## Requirements
- R1: After reset every select is high and both int_ack and ext_cycle are low. Channel 0's control word is reset to wait states 15, byte-enable mode 1, burst read and burst write 0, auto-acknowledge BOOT_AA and port size BOOT_PS. The other channels reset to all zero.
- R2: A channel's base is compared with bus_addr[31:16]. Any address bit whose mask bit is 1 is a don't-care. For example, base 0x0000 with mask 0x0008 hits 0x00000000–0x0000FFFF and 0x00080000–0x0008FFFF and nothing else.
- R3: Outside global mode, a channel whose valid bit is 0 never matches.
- R4: From reset until channel 0's mask word is written with bit 0 set, every access selects channel 0 alone. In that mode the base, the mask, the attributes and the other channels are all ignored.
- R5: An access is blocked when it is CPU-space and the CPU mask bit is set. A non-CPU access is blocked when the mask bit for its class is set; the classes are supervisor code, supervisor data, user code and user data.
- R6: A non-CPU external-master access is blocked when the external-master mask bit is 1. When that bit is 0, the four supervisor/user code/data mask bits are ignored for such an access.
- R7: A write to a channel whose write-protect bit is set does not select it. Reads still do, and no error is raised.
- R8: If no channel matches, or two or more do, no select asserts and ext_cycle is high for the whole cycle. In that cycle port_size is 00 and both burst flags are 0.
- R9: On a single match with auto-acknowledge set and wait count N, the select asserts in the cycle after the start strobe is sampled. int_ack is high for exactly one cycle, N cycles after the select first appears, and the bus cycle ends at the next edge. With auto-acknowledge clear, int_ack stays low.
- R10: While a channel is selected, port_size reports the channel's size as 00 (32-bit), 01 (8-bit) or 10 (16-bit); a stored 11 is reported as 10. burst_rd, burst_wr and be_on_read copy the channel's flags.
- R11: An ext_ack sampled during a cycle ends that cycle at the same edge, whatever the mode. All selects and ext_cycle drop in the following cycle. A start strobe that arrives while a cycle is open is ignored.
- R12: A configuration write sets cfg_we and places a channel number on cfg_ch. cfg_sel = 00 writes the base from cfg_wdata[15:0]. cfg_sel = 01 writes the mask word: [31:16] address mask, [7] write-protect, [6] external master, [5] CPU, [4] supervisor code, [3] supervisor data, [2] user code, [1] user data, [0] valid. cfg_sel = 10 writes the control word: [3:0] wait states, [4] auto-acknowledge, [6:5] port size, [7] byte-enable mode, [8] burst read, [9] burst write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel being written |
| cfg_sel | input | 2 | Which word is written (base, mask, control) |
| cfg_wdata | input | 32 | Configuration data |
| bus_start | input | 1 | Start of a bus cycle; address and attributes are valid |
| bus_addr | input | 32 | Access address |
| bus_write | input | 1 | 1 for a write access |
| bus_super | input | 1 | 1 for a supervisor access |
| bus_code | input | 1 | 1 for a code fetch |
| bus_cpu | input | 1 | 1 for a CPU-space or interrupt-acknowledge access |
| bus_ext_master | input | 1 | 1 when an external master drives the access |
| ext_ack | input | 1 | External transfer acknowledge |
| cs_n | output | 8 | Active-low chip selects |
| int_ack | output | 1 | Internal transfer acknowledge |
| ext_cycle | output | 1 | The current cycle matched no single channel |
| port_size | output | 2 | Port size of the selected channel |
| burst_rd | output | 1 | Burst reads allowed |
| burst_wr | output | 1 | Burst writes allowed |
| be_on_read | output | 1 | Byte enables also asserted on reads |

## Verification
The assertions check several rules on every cycle. At most one select is low. An external cycle never carries a select, a port size or a burst flag. int_ack is a single-cycle pulse that only appears under an active select. The selects hold steady until the cycle ends, and they clear on the cycle after it ends. The decode rules need the bench's scenarios to show them, because only a specific address and attribute pattern reveals a wrong answer. These rules are the masked windows, global boot mode and its exit, the valid, space, external-master and write-protect blocking, the multiple-match fallback, the exact wait count and port-size normalisation.

// File: rtl/cs_decoder.sv
module cs_decoder #(
  parameter int NCH = 8,
  parameter int ADDR_W = 32,
  parameter bit BOOT_AA = 1'b1,
  parameter logic [1:0] BOOT_PS = 2'b00
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [$clog2(NCH)-1:0] cfg_ch,
  input  logic [1:0]             cfg_sel,
  input  logic [31:0]            cfg_wdata,
  input  logic                   bus_start,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_write,
  input  logic                   bus_super,
  input  logic                   bus_code,
  input  logic                   bus_cpu,
  input  logic                   bus_ext_master,
  input  logic                   ext_ack,
  output logic [NCH-1:0]         cs_n,
  output logic                   int_ack,
  output logic                   ext_cycle,
  output logic [1:0]             port_size,
  output logic                   burst_rd,
  output logic                   burst_wr,
  output logic                   be_on_read
);
  localparam int CH_W = $clog2(NCH);
  localparam int BASE_W = 16;
  localparam int WS_W = 4;
  localparam int CTRL_W = 10;
  localparam int SP_V = 0, SP_UD = 1, SP_UC = 2, SP_SD = 3, SP_SC = 4, SP_CPU = 5, SP_EM = 6, SP_WP = 7;

  logic [BASE_W-1:0] base_r  [NCH];
  logic [BASE_W-1:0] amask_r [NCH];
  logic [7:0]        sp_r    [NCH];
  logic [CTRL_W-1:0] ctrl_r  [NCH];
  logic              global_q;

  logic [NCH-1:0]    hit;
  logic              single;
  logic [CH_W-1:0]   hit_idx;
  logic [CTRL_W-1:0] hit_ctrl;

  logic              busy_q, aa_q, ext_q, brd_q, bwr_q, bem_q;
  logic [NCH-1:0]    sel_q;
  logic [WS_W-1:0]   cnt_q;
  logic [1:0]        ps_q;
  logic              accept, done;
  logic              unused_bits;

  assign unused_bits = ^cfg_wdata[15:10];

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    logic addr_ok, space_ok, wr_ok, normal_hit;
    assign addr_ok = ((bus_addr[ADDR_W-1 -: BASE_W] ^ base_r[i]) & ~amask_r[i]) == '0;
    assign space_ok = bus_cpu        ? !sp_r[i][SP_CPU] :
                      bus_ext_master ? !sp_r[i][SP_EM]  :
                      bus_super      ? (bus_code ? !sp_r[i][SP_SC] : !sp_r[i][SP_SD]) :
                                       (bus_code ? !sp_r[i][SP_UC] : !sp_r[i][SP_UD]);
    assign wr_ok = !(bus_write && sp_r[i][SP_WP]);
    assign normal_hit = sp_r[i][SP_V] && addr_ok && space_ok && wr_ok;
    assign hit[i] = global_q ? (i == 0) : normal_hit;
  end

  assign single = (hit != '0) && ((hit & (hit - 1'b1)) == '0);

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NCH; i++)
      if (hit[i]) hit_idx = CH_W'(i);
  end

  assign hit_ctrl = ctrl_r[hit_idx];
  assign accept   = bus_start && !busy_q;
  assign int_ack  = busy_q && aa_q && (cnt_q == '0);
  assign done     = busy_q && (int_ack || ext_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      global_q <= 1'b1;
      for (int i = 0; i < NCH; i++) begin
        base_r[i]  <= '0;
        amask_r[i] <= '0;
        sp_r[i]    <= '0;
        ctrl_r[i]  <= (i == 0) ? {1'b0, 1'b0, 1'b1, BOOT_PS, BOOT_AA, 4'hF} : '0;
      end
    end else if (cfg_we && (int'(cfg_ch) < NCH)) begin
      case (cfg_sel)
        2'b00: base_r[cfg_ch] <= cfg_wdata[15:0];
        2'b01: begin
          amask_r[cfg_ch] <= cfg_wdata[31:16];
          sp_r[cfg_ch]    <= cfg_wdata[7:0];
          if (cfg_ch == '0 && cfg_wdata[SP_V]) global_q <= 1'b0;
        end
        2'b10: ctrl_r[cfg_ch] <= cfg_wdata[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sel_q <= '0; cnt_q <= '0; aa_q <= 1'b0; ext_q <= 1'b0;
      ps_q <= 2'b00; brd_q <= 1'b0; bwr_q <= 1'b0; bem_q <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      if (single) begin
        sel_q <= hit;
        cnt_q <= hit_ctrl[3:0];
        aa_q  <= hit_ctrl[4];
        ps_q  <= (hit_ctrl[6:5] == 2'b11) ? 2'b10 : hit_ctrl[6:5];
        bem_q <= hit_ctrl[7];
        brd_q <= hit_ctrl[8];
        bwr_q <= hit_ctrl[9];
        ext_q <= 1'b0;
      end else begin
        sel_q <= '0; cnt_q <= '0; aa_q <= 1'b0; ps_q <= 2'b00;
        bem_q <= 1'b0; brd_q <= 1'b0; bwr_q <= 1'b0; ext_q <= 1'b1;
      end
    end else if (done) begin
      busy_q <= 1'b0; sel_q <= '0; aa_q <= 1'b0; ext_q <= 1'b0;
      ps_q <= 2'b00; brd_q <= 1'b0; bwr_q <= 1'b0; bem_q <= 1'b0;
    end else if (busy_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cs_n       = ~sel_q;
  assign ext_cycle  = ext_q;
  assign port_size  = ps_q;
  assign burst_rd   = brd_q;
  assign burst_wr   = bwr_q;
  assign be_on_read = bem_q;

  // R8
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));
  // R8
  ext_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cycle |-> (cs_n == '1 && port_size == 2'b00 && !burst_rd && !burst_wr));
  // R9
  ack_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> (cs_n != '1 && !ext_cycle));
  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) int_ack |=> !int_ack);
  // R11
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> $stable(cs_n));
  // R11
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cs_n == '1 && !ext_cycle));
endmodule

// File: tb/cs_decoder_test.sv
module cs_decoder_test;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [2:0] cfg_ch = 0; logic [1:0] cfg_sel = 0; logic [31:0] cfg_wdata = 0;
  logic bus_start = 0, bus_write = 0, bus_super = 0, bus_code = 0, bus_cpu = 0, bus_ext_master = 0, ext_ack = 0;
  logic [31:0] bus_addr = 0;
  logic [7:0] cs_n; logic int_ack, ext_cycle, burst_rd, burst_wr, be_on_read; logic [1:0] port_size;

  always #2 clk = ~clk;

  cs_decoder uut (.clk, .rst_n, .cfg_we, .cfg_ch, .cfg_sel, .cfg_wdata, .bus_start, .bus_addr,
    .bus_write, .bus_super, .bus_code, .bus_cpu, .bus_ext_master, .ext_ack, .cs_n, .int_ack,
    .ext_cycle, .port_size, .burst_rd, .burst_wr, .be_on_read);

  int checks = 0, errors = 0;
  bit cmp_on = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  // reference model
  int m_base[8], m_amask[8], m_sp[8], m_ctrl[8];
  bit m_global, m_busy, m_aa, m_ext;
  int m_sel, m_cnt;

  function automatic int ref_decode();
    int found = -1, n = 0;
    if (m_global) return 0;
    for (int c = 0; c < 8; c++) begin
      bit blocked;
      if ((m_sp[c] & 1) == 0) continue;
      if (((int'(bus_addr[31:16]) ^ m_base[c]) & ~m_amask[c] & 'hFFFF) != 0) continue;
      if (bus_cpu) blocked = m_sp[c][5];
      else if (bus_ext_master) blocked = m_sp[c][6];
      else if (bus_super) blocked = bus_code ? m_sp[c][4] : m_sp[c][3];
      else blocked = bus_code ? m_sp[c][2] : m_sp[c][1];
      if (bus_write && m_sp[c][7]) blocked = 1;
      if (blocked) continue;
      n++; found = c;
    end
    return (n == 1) ? found : -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 8; c++) begin m_base[c] = 0; m_amask[c] = 0; m_sp[c] = 0; m_ctrl[c] = 0; end
      m_ctrl[0] = 'h09F; m_global = 1; m_busy = 0; m_sel = -1; m_cnt = 0; m_aa = 0; m_ext = 0;
    end else begin
      bit iack;
      iack = m_busy && m_aa && m_cnt == 0;
      if (!m_busy && bus_start) begin
        m_busy = 1; m_sel = ref_decode();
        m_ext = (m_sel < 0);
        m_aa = (m_sel >= 0) ? m_ctrl[m_sel][4] : 0;
        m_cnt = (m_sel >= 0) ? m_ctrl[m_sel] & 15 : 0;
      end else if (m_busy && (iack || ext_ack)) begin
        m_busy = 0; m_sel = -1; m_ext = 0; m_aa = 0;
      end else if (m_busy && m_cnt > 0) m_cnt--;
      if (cfg_we) begin
        if (cfg_sel == 0) m_base[cfg_ch] = cfg_wdata & 'hFFFF;
        if (cfg_sel == 1) begin
          m_amask[cfg_ch] = cfg_wdata >> 16; m_sp[cfg_ch] = cfg_wdata & 'hFF;
          if (cfg_ch == 0 && cfg_wdata[0]) m_global = 0;
        end
        if (cfg_sel == 2) m_ctrl[cfg_ch] = cfg_wdata & 'h3FF;
      end
    end
  end

  bit ack_seen;
  always @(negedge clk) if (cmp_on) begin
    logic [7:0] ecs; int ps, ec;
    ecs = (m_busy && m_sel >= 0) ? ~(8'd1 << m_sel) : 8'hFF;
    ec = (m_sel >= 0) ? m_ctrl[m_sel] : 0;
    ps = (m_busy && m_sel >= 0) ? (((ec >> 5) & 3) == 3 ? 2 : (ec >> 5) & 3) : 0;
    check(cs_n === ecs, "R2 cycle cs_n", cs_n, ecs);
    check(int_ack === (m_busy && m_aa && m_cnt == 0), "R9 cycle int_ack", int_ack, m_busy && m_aa && m_cnt == 0);
    check(ext_cycle === (m_busy && m_ext), "R8 cycle ext_cycle", ext_cycle, m_busy && m_ext);
    check(port_size === 2'(ps), "R10 cycle port_size", port_size, ps);
    check(burst_rd === (m_busy && m_sel >= 0 && ec[8]), "R10 cycle burst_rd", burst_rd, ec[8]);
    check(burst_wr === (m_busy && m_sel >= 0 && ec[9]), "R10 cycle burst_wr", burst_wr, ec[9]);
    check(be_on_read === (m_busy && m_sel >= 0 && ec[7]), "R10 cycle be_on_read", be_on_read, ec[7]);
    if (int_ack) ack_seen = 1;
  end

  task automatic cfg(input int ch, input int sel, input logic [31:0] d);
    @(posedge clk); #1; cfg_we = 1; cfg_ch = 3'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
    @(posedge clk); #1; cfg_we = 0;
  endtask

  logic [7:0] got_cs; bit got_ext, got_brd, got_bem; logic [1:0] got_ps; int waits;

  task automatic access(input logic [31:0] a, input bit w, s, c, cpu, em, give_ext);
    @(posedge clk); #1;
    bus_addr = a; bus_write = w; bus_super = s; bus_code = c; bus_cpu = cpu; bus_ext_master = em;
    bus_start = 1; ack_seen = 0;
    @(posedge clk); #1; bus_start = 0;
    @(negedge clk); got_cs = cs_n; got_ext = ext_cycle; got_ps = port_size; got_brd = burst_rd; got_bem = be_on_read;
    waits = 0;
    if (give_ext) begin
      @(posedge clk); #1; ext_ack = 1;
      @(posedge clk); #1; ext_ack = 0;
    end else begin
      while (!int_ack && waits < 40) begin @(negedge clk); waits++; end
      @(posedge clk); #1;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++; $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk); #1; rst_n = 1; cmp_on = 1;
    @(negedge clk);
    check(cs_n === 8'hFF && !int_ack && !ext_cycle, "R1 reset outputs", {cs_n, int_ack, ext_cycle}, 'h3FC);

    // R4 global boot select, R1 channel 0 reset control
    access(32'h1234_5678, 0, 0, 0, 0, 0, 0);
    check(got_cs === 8'hFE, "R4 global select", got_cs, 8'hFE);
    check(waits == 15, "R1 boot wait states", waits, 15);
    check(got_bem && !got_brd && got_ps == 2'b00, "R1 boot control", {got_bem, got_brd, got_ps}, 'h8);
    access(32'hFFFF_0000, 1, 1, 1, 1, 1, 0);
    check(got_cs === 8'hFE, "R4 global ignores attributes", got_cs, 8'hFE);

    // channel 1 valid while global: still only channel 0
    cfg(1, 0, 32'h0010); cfg(1, 2, 32'h0032); cfg(1, 1, 32'h0000_0001);
    access(32'h0010_0000, 0, 0, 0, 0, 0, 0);
    check(got_cs === 8'hFE, "R4 others suppressed in global mode", got_cs, 8'hFE);

    // leave global mode; channel 0 mask 0x0008, ps=11 burst read
    cfg(0, 0, 32'h0000); cfg(0, 2, 32'h0170); cfg(0, 1, 32'h0008_0001);
    access(32'h0008_0010, 0, 0, 0, 0, 0, 0);
    check(got_cs === 8'hFE, "R2 upper window", got_cs, 8'hFE);
    check(got_ps === 2'b10 && got_brd, "R10 port size 11 reported as 10", got_ps, 2'b10);
    check(waits == 0, "R9 zero wait states", waits, 0);
    access(32'h0000_FFFF, 1, 0, 0, 0, 0, 0);
    check(got_cs === 8'hFE, "R2 lower window", got_cs, 8'hFE);
    access(32'h0009_0000, 0, 0, 0, 0, 0, 1);
    check(got_cs === 8'hFF && got_ext, "R8 no match outside windows", got_cs, 8'hFF);

    access(32'h0010_1234, 0, 0, 0, 0, 0, 0);
    check(got_cs === 8'hFD && waits == 2, "R9 channel 1 two wait states", waits, 2);
    check(got_ps === 2'b01, "R10 8-bit port", got_ps, 2'b01);

    // R3 valid bit
    cfg(2, 0, 32'h0020); cfg(2, 2, 32'h0011);
    access(32'h0020_0000, 0, 0, 0, 0, 0, 1);
    check(got_cs === 8'hFF && got_ext, "R3 invalid channel ignored", got_cs, 8'hFF);
    cfg(2, 1, 32'h0000_0001);
    access(32'h0020_0000, 0, 0, 0, 0, 0, 0);
    check(got_cs === 8'hFB, "R3 valid channel selects", got_cs, 8'hFB);

    // R5 space masks: supervisor data and CPU blocked
    cfg(2, 1, 32'h0000_0029);
    access(32'h0020_0000, 0, 1, 0, 0, 0, 1);
    check(got_cs === 8'hFF, "R5 supervisor data blocked", got_cs, 8'hFF);
    access(32'h0020_0000, 0, 1, 1, 0, 0, 0);
    check(got_cs === 8'hFB, "R5 supervisor code allowed", got_cs, 8'hFB);
    access(32'h0020_0000, 0, 0, 0, 0, 0, 0);
    check(got_cs === 8'hFB, "R5 user data allowed", got_cs, 8'hFB);
    access(32'h0020_0000, 0, 1, 0, 1, 0, 1);
    check(got_cs === 8'hFF, "R5 cpu space blocked", got_cs, 8'hFF);

    // R6 external master
    cfg(2, 1, 32'h0000_001F);
    access(32'h0020_0000, 0, 0, 0, 0, 1, 0);
    check(got_cs === 8'hFB, "R6 external master ignores s/u masks", got_cs, 8'hFB);
    access(32'h0020_0000, 0, 0, 0, 0, 0, 1);
    check(got_cs === 8'hFF, "R6 internal user data still blocked", got_cs, 8'hFF);
    cfg(2, 1, 32'h0000_0041);
    access(32'h0020_0000, 0, 0, 0, 0, 1, 1);
    check(got_cs === 8'hFF, "R6 external master mask blocks", got_cs, 8'hFF);

    // R7 write protect
    cfg(2, 1, 32'h0000_0081);
    access(32'h0020_0004, 1, 0, 0, 0, 0, 1);
    check(got_cs === 8'hFF && got_ext, "R7 protected write", got_cs, 8'hFF);
    access(32'h0020_0004, 0, 0, 0, 0, 0, 0);
    check(got_cs === 8'hFB, "R7 read allowed", got_cs, 8'hFB);

    // R8 multiple match
    cfg(3, 0, 32'h0020); cfg(3, 2, 32'h0010); cfg(3, 1, 32'h0000_0001);
    access(32'h0020_0000, 0, 0, 0, 0, 0, 1);
    check(got_cs === 8'hFF && got_ext, "R8 two channels match", got_cs, 8'hFF);

    // R9 auto-acknowledge off
    cfg(1, 2, 32'h0002);
    access(32'h0010_0000, 0, 0, 0, 0, 0, 1);
    check(got_cs === 8'hFD && !ack_seen, "R9 no int_ack without auto-ack", ack_seen, 0);

    // R11 start while busy ignored
    @(posedge clk); #1; bus_addr = 32'h0010_0000; bus_write = 0; bus_cpu = 0; bus_ext_master = 0; bus_start = 1;
    @(posedge clk); #1; bus_addr = 32'h0008_0000;
    @(posedge clk); #1; bus_start = 0;
    @(negedge clk);
    check(cs_n === 8'hFD, "R11 start while busy ignored", cs_n, 8'hFD);
    @(posedge clk); #1; ext_ack = 1;
    @(posedge clk); #1; ext_ack = 0;
    @(negedge clk);
    check(cs_n === 8'hFF, "R11 released after ext_ack", cs_n, 8'hFF);

    // R11 ext_ack cuts an auto-ack cycle short
    cfg(1, 2, 32'h001F);
    access(32'h0010_0000, 0, 0, 0, 0, 0, 1);
    @(negedge clk);
    check(got_cs === 8'hFD && !ack_seen && cs_n === 8'hFF, "R11 ext_ack ends auto-ack cycle", ack_seen, 0);

    // R12 unused select code writes nothing
    cfg(1, 3, 32'h0000_0000);
    access(32'h0010_0000, 0, 0, 0, 0, 0, 0);
    check(got_cs === 8'hFD && waits == 15, "R12 cfg_sel 11 ignored", waits, 15);

    repeat (3) @(posedge clk);
    summary();
  end
endmodule